// File: doc/BRIEF.md
# Remote Carrier Waveform Generator

This block makes the carrier for an infrared remote transmitter. It divides the system clock to a fixed carrier frequency and drives the result onto one output pin. A 2-bit mode register, written by software at any time, selects one of four waveforms. Two of them divide by twelve, one with a one-third duty cycle and one with a one-quarter duty cycle. One divides by eight at half duty. The fourth sends no carrier, and the pin then works as an ordinary output port bit.

The burst enable input gates the carrier, so toggling it produces the modulated bursts of a remote-control frame. Each burst starts at the beginning of a carrier period, in its high phase. A write that changes the mode also restarts the period. A write of the value already held leaves the phase as it was.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode register clears to 2'b00 (no carrier) and the divider clears to zero, so after reset `carrier_out` follows `port_bit`.
- R2: Mode 2'b01 produces a period of 12 clocks: high for the first 4 clocks, low for the other 8.
- R3: Mode 2'b10 produces a period of 12 clocks: high for the first 3 clocks, low for the other 9.
- R4: Mode 2'b11 produces a period of 8 clocks: high for the first 4 clocks, low for the other 4.
- R5: In mode 2'b00, `carrier_out` equals `port_bit` in the same cycle.
- R6: In a carrier mode, `carrier_out` is low while `burst_en` is low. When `burst_en` returns high, a new period begins with its high phase in that same cycle.
- R7: A write (`mode_we` high) of a value that differs from the current mode takes effect at the next edge and starts a fresh period from its high phase. A write of the current value leaves the running phase unchanged.
- R8: In the carrier modes, `port_bit` has no effect on `carrier_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the carrier is divided from |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | Mode value to write: 00 none, 01 div12 1/3, 10 div12 1/4, 11 div8 1/2 |
| burst_en | input | 1 | Gates the carrier on (high) or forces it low |
| port_bit | input | 1 | Output port data, driven onto the pin in mode 00 |
| carrier_out | output | 1 | Shared carrier / port output pin |

## Verification
The bench builds the block with its default parameters: a long period of 12, a short period of 8, and high phases of 4, 3 and 4. With these values a whole period of every mode takes no more than a dozen cycles. Thousands of random cycles can therefore reach mid-period mode writes, same-value writes, burst gaps at every phase, and wrap-arounds in all modes. They then sit beside the directed runs of each mode.

// File: rtl/ir_carrier_pkg.sv
// Package: shared mode encoding for the remote carrier generator.
// Assumes a 2-bit mode field written by software.
package ir_carrier_pkg;
    typedef enum logic [1:0] {
        CAR_OFF     = 2'b00,   // pin is a plain output bit
        CAR_THIRD   = 2'b01,   // long period, one-third high
        CAR_QUARTER = 2'b10,   // long period, one-quarter high
        CAR_HALF    = 2'b11    // short period, half high
    } car_mode_e;
endpackage

// File: rtl/ir_mode_reg.sv
// Module: holds the software-selected carrier mode.
// Flags a write whose value differs from the held mode, so the divider
// can restart in the same edge the new mode is loaded.
module ir_mode_reg
    import ir_carrier_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] wdata,
    output car_mode_e  mode,
    output logic       change
);
    car_mode_e mode_q;

    // A write of a new value means the mode changes at the next edge.
    assign change = we && (car_mode_e'(wdata) != mode_q);
    assign mode   = mode_q;

    // Mode register: cleared to no-carrier by reset, loaded on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= CAR_OFF;
        else if (we)
            mode_q <= car_mode_e'(wdata);
    end

    // After a reset edge the mode must read as no-carrier.
    assert_reset_mode_R1: assert property (@(posedge clk)
        !rst_n |=> mode_q == CAR_OFF);

    // A write of the held value must leave the mode untouched.
    assert_same_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !change) |=> $stable(mode_q));
endmodule

// File: rtl/ir_divider.sv
// Module: period counter for the carrier.
// Counts 0..period-1 while running and wraps. It is held at zero when
// stopped or restarted, so every period begins at count zero.
module ir_divider
    import ir_carrier_pkg::*;
#(
    parameter int LONG_DIV  = 12,
    parameter int SHORT_DIV = 8,
    localparam int MAX_DIV  = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV,
    localparam int CNT_W    = $clog2(MAX_DIV)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  car_mode_e        mode,
    input  logic             run,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Last count of a period, picked by the active mode.
    always_comb begin
        if (mode == CAR_HALF)
            last = CNT_W'(SHORT_DIV - 1);
        else
            last = CNT_W'(LONG_DIV - 1);
    end

    // Counter: cleared on reset, restart or stop, and wraps at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            cnt_q <= '0;
        else if (cnt_q == last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    // The count never reaches the longest period length.
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(MAX_DIV));

    // A mode change always restarts the period.
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

    // A stopped divider sits at zero.
    assert_stop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/ir_shaper.sv
// Module: turns the period count into the pin level.
// The high phase occupies the first counts of a period. In no-carrier
// mode the pin carries port data. Purely combinational.
module ir_shaper
    import ir_carrier_pkg::*;
#(
    parameter int HI_THIRD   = 4,
    parameter int HI_QUARTER = 3,
    parameter int HI_HALF    = 4,
    parameter int CNT_W      = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  car_mode_e        mode,
    input  logic [CNT_W-1:0] count,
    input  logic             gate,
    input  logic             port_bit,
    output logic             pin
);
    logic [CNT_W-1:0] high_len;

    // Number of high clocks at the start of a period for the active mode.
    always_comb begin
        unique case (mode)
            CAR_THIRD:   high_len = CNT_W'(HI_THIRD);
            CAR_QUARTER: high_len = CNT_W'(HI_QUARTER);
            CAR_HALF:    high_len = CNT_W'(HI_HALF);
            default:     high_len = '0;
        endcase
    end

    // Pin level: port data when off, otherwise the gated high phase.
    always_comb begin
        if (mode == CAR_OFF)
            pin = port_bit;
        else
            pin = gate && (count < high_len);
    end

    // A gated, running carrier starts each period high.
    assert_period_starts_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CAR_OFF && gate && count == '0) |-> pin);

    // The quarter-duty mode is never high past count HI_QUARTER-1.
    assert_quarter_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAR_QUARTER && pin) |-> count < CNT_W'(HI_QUARTER));
endmodule

// File: rtl/ir_carrier_gen.sv
// Module: top of the remote carrier generator.
// Ties the mode register, the period divider and the output shaper together.
// Assumes clk is the system clock the carrier is divided from and that
// rst_n is synchronous to it.
module ir_carrier_gen
    import ir_carrier_pkg::*;
#(
    parameter int LONG_DIV   = 12,
    parameter int SHORT_DIV  = 8,
    parameter int HI_THIRD   = 4,
    parameter int HI_QUARTER = 3,
    parameter int HI_HALF    = 4,
    localparam int MAX_DIV   = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV,
    localparam int CNT_W     = $clog2(MAX_DIV)
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    input  logic       burst_en,
    input  logic       port_bit,
    output logic       carrier_out
);
    car_mode_e        mode;
    logic             mode_change;
    logic             run;
    logic [CNT_W-1:0] count;

    // The divider runs only in a carrier mode with the burst gate open.
    assign run = burst_en && (mode != CAR_OFF);

    ir_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mode_we),
        .wdata  (mode_wdata),
        .mode   (mode),
        .change (mode_change)
    );

    ir_divider #(
        .LONG_DIV  (LONG_DIV),
        .SHORT_DIV (SHORT_DIV)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .run     (run),
        .restart (mode_change),
        .count   (count)
    );

    ir_shaper #(
        .HI_THIRD   (HI_THIRD),
        .HI_QUARTER (HI_QUARTER),
        .HI_HALF    (HI_HALF),
        .CNT_W      (CNT_W)
    ) u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .count    (count),
        .gate     (burst_en),
        .port_bit (port_bit),
        .pin      (carrier_out)
    );

    // The pin is low whenever the gate is closed in a carrier mode.
    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CAR_OFF && !burst_en) |-> !carrier_out);

    // Port data reaches the pin in no-carrier mode.
    assert_port_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CAR_OFF) |-> carrier_out == port_bit);
endmodule

// File: tb/ir_carrier_gen_test.sv
// Bench: directed runs of every mode plus seeded random traffic, checked
// against a reference built from the requirements.
module ir_carrier_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       burst_en = 1'b0;
    logic       port_bit = 1'b0;
    logic       carrier_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state: the mode and the position within the period.
    int m_mode = 0;
    int m_pos = 0;

    always #2 clk = ~clk;   // 250 MHz

    ir_carrier_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_we     (mode_we),
        .mode_wdata  (mode_wdata),
        .burst_en    (burst_en),
        .port_bit    (port_bit),
        .carrier_out (carrier_out)
    );

    function automatic int period_of(int md);
        return (md == 3) ? 8 : 12;
    endfunction

    function automatic int high_of(int md);
        case (md)
            1: return 4;
            2: return 3;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit expect_pin(int md, int pos, bit en, bit pb);
        if (md == 0) return pb;
        return en && (pos < high_of(md));
    endfunction

    function automatic string auto_tag(int md, bit en);
        if (md == 0) return "R5";
        if (!en) return "R6";
        if (md == 1) return "R2";
        if (md == 2) return "R3";
        return "R4";
    endfunction

    // One clock: drive after the falling edge, check, then advance the reference.
    task automatic cycle(bit rst, bit we, int din, bit en, bit pb, string tag);
        bit exp;
        string t;
        @(negedge clk);
        rst_n = !rst; mode_we = we; mode_wdata = 2'(din);
        burst_en = en; port_bit = pb;
        #1;
        exp = expect_pin(m_mode, m_pos, en, pb);
        t = (tag == "") ? auto_tag(m_mode, en) : tag;
        n_checks++;
        if (carrier_out !== exp) begin
            n_fail++;
            $display("FAIL %s: carrier_out=%b expected=%b (mode=%0d pos=%0d)",
                     t, carrier_out, exp, m_mode, m_pos);
        end
        if (rst) begin
            m_mode = 0; m_pos = 0;
        end else if (we && din != m_mode) begin
            m_mode = din; m_pos = 0;
        end else if (!en || m_mode == 0) begin
            m_pos = 0;
        end else begin
            m_pos = (m_pos == period_of(m_mode) - 1) ? 0 : m_pos + 1;
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h1d5a_9e03);
        // R1: reset lands in no-carrier mode; the first check only settles the reference.
        cycle(1, 0, 0, 1, 1, "R1");
        cycle(1, 1, 3, 1, 1, "R1");
        cycle(1, 0, 0, 1, 0, "R1");
        cycle(0, 0, 0, 1, 1, "R1");
        // R5: port data follows the pin directly
        for (int i = 0; i < 6; i++) cycle(0, 0, 0, 0, bit'(i % 2), "R5");
        // R2: divide by 12, one-third duty, two periods
        cycle(0, 1, 1, 1, 0, "R2");
        for (int i = 0; i < 24; i++) cycle(0, 0, 0, 1, 0, "R2");
        // R8: port data toggling has no effect in a carrier mode
        for (int i = 0; i < 12; i++) cycle(0, 0, 0, 1, bit'(i % 2), "R8");
        // R7: writing the held value mid-period keeps the phase
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 1, 0, "R2");
        cycle(0, 1, 1, 1, 0, "R7");
        for (int i = 0; i < 12; i++) cycle(0, 0, 0, 1, 0, "R7");
        // R3: divide by 12, one-quarter duty, entered mid-period
        cycle(0, 1, 2, 1, 0, "R7");
        for (int i = 0; i < 24; i++) cycle(0, 0, 0, 1, 0, "R3");
        // R4: divide by 8, half duty
        cycle(0, 1, 3, 1, 1, "R7");
        for (int i = 0; i < 20; i++) cycle(0, 0, 0, 1, 0, "R4");
        // R6: gate low forces the pin low, even with port data high; re-enable restarts high
        for (int i = 0; i < 5; i++) cycle(0, 0, 0, 0, 1, "R6");
        for (int i = 0; i < 10; i++) cycle(0, 0, 0, 1, 0, "R6");
        cycle(0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 8; i++) cycle(0, 0, 0, 1, 0, "R6");
        // Random traffic: rare mode writes, occasional gate flips, random port data
        begin
            bit en = 1'b1;
            for (int i = 0; i < 4000; i++) begin
                bit we;
                we = ($urandom % 16) == 0;
                if (($urandom % 20) == 0) en = !en;
                cycle(($urandom % 1000) == 0, we, int'($urandom % 4), en,
                      bit'($urandom % 2), "");
            end
        end
        // R1: reset in the middle of a carrier returns the pin to port data
        cycle(0, 1, 1, 1, 0, "R1");
        cycle(1, 0, 0, 1, 0, "R1");
        cycle(0, 0, 0, 1, 1, "R1");
        cycle(0, 0, 0, 1, 0, "R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule